// File: doc/BRIEF.md
# Smooth Digital Clock Trim

This block fine-tunes the effective frequency of a slow real-time clock. It runs on that clock. Each cycle it tells the downstream prescaler how many clock pulses to count: normally one, none when a pulse is removed, and two when a pulse is added. Over a calibration window of 2^W cycles (32 s at 32768 Hz with the default W = 20), the block removes a programmable number of pulses, from 0 to 511. If the add bit is set, it also adds 512 pulses. Shorter windows of half and a quarter of that length keep the same rate of correction with coarser resolution.

The window is split into 512 slots of 2^(W-9) cycles each. A pulse is removed in the first cycle of a slot when the bit-reversed slot number is below the effective mask count. This spreads the removals evenly across the window. An added pulse lands in the middle cycle of a slot, so it never shares a cycle with a removal. Software writes a new setting with a one-cycle strobe. The setting waits in a shadow register, with a pending flag raised, until the current window ends.

Top module: `rtc_trim`

## Requirements
- R1: After reset the pending flag is 0 and the active setting is the longest window with no addition and a mask count of 0, so `tick_o` is 1 in every cycle.
- R2: The window selection encodes the window length. Bit 0 set selects 2^(W-2) cycles, and it wins over bit 1. Bit 1 alone selects 2^(W-1) cycles. 2'b00 selects 2^W cycles. The cycle counter restarts at 0 after the last cycle of a window.
- R3: In a 2^W-cycle window, the sum of `tick_o` equals 2^W + 512*add − mask.
- R4: In a 2^(W-1)-cycle window, mask bit 0 is ignored, and the sum equals 2^(W-1) + 256*add − mask[8:1].
- R5: In a 2^(W-2)-cycle window, mask bits 1:0 are ignored, and the sum equals 2^(W-2) + 128*add − mask[8:2].
- R6: A write strobe sets `pending_o` on the next cycle. The stored setting becomes active at the first cycle of the next window, and `pending_o` is 0 in that cycle.
- R7: `tick_o` only takes the values 0, 1 or 2.
- R8: A removal (`tick_o` = 0) only occurs in the first cycle of a slot, and an addition (`tick_o` = 2) only in the middle cycle of a slot. With mask count 256 in the longest window, exactly every second slot, starting with slot 0, loses a pulse.
- R9: A write in the last cycle of a window does not affect the window that follows. It stays pending through that window and applies one window later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Real-time clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Write strobe for a new trim setting |
| cfg_win | input | 2 | Window selection (bit 0: quarter, bit 1: half, none: full) |
| cfg_add | input | 1 | Add 512 pulses per full window |
| cfg_mask | input | 9 | Pulses to remove per full window |
| pending_o | output | 1 | A written setting has not yet been applied |
| tick_o | output | 2 | Pulses for the prescaler this cycle (0, 1 or 2) |

## Verification
The hardest case to reach from the ports is a write that lands in exactly the last cycle of a window. The bench gets there by counting cycles from the first cycle of a window, which it identifies by the falling edge of the pending flag, then strobes the write len−1 cycles later. It then confirms that the following window still carries the old sum. For the even-spreading property, it logs the cycle index of every removal and addition in a run with mask count 256, and compares the positions with the slot arithmetic. The bench uses W = 10, so that all three window lengths, both add settings and a spread of mask values, including the ignored low bits, fit into one run.

// File: rtl/rtc_trim.sv
module rtc_trim #(
  parameter int W = 20
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_we,
  input  logic [1:0] cfg_win,
  input  logic       cfg_add,
  input  logic [8:0] cfg_mask,
  output logic       pending_o,
  output logic [1:0] tick_o
);
  localparam int SL = W - 9;
  localparam logic [SL-1:0] MID = SL'(1) << (SL - 1);

  logic [1:0] sh_win, act_win;
  logic       sh_add, act_add;
  logic [8:0] sh_mask, act_mask;
  logic       pend;
  logic [W-1:0] cnt;

  logic [1:0]   k;
  logic [W-1:0] last_cnt;
  logic         at_end;
  logic [8:0]   slot, rslot, m_eff;
  logic         cut, ins;

  assign k        = act_win[0] ? 2'd2 : (act_win[1] ? 2'd1 : 2'd0);
  assign last_cnt = {W{1'b1}} >> k;
  assign at_end   = (cnt == last_cnt);
  assign slot     = cnt[W-1:SL];

  always_comb
    for (int i = 0; i < 9; i++) rslot[i] = slot[8-i];

  assign m_eff     = act_mask & ~((9'd1 << k) - 9'd1);
  assign cut       = (cnt[SL-1:0] == '0) && (rslot < m_eff);
  assign ins       = act_add && (cnt[SL-1:0] == MID);
  assign tick_o    = 2'd1 + {1'b0, ins} - {1'b0, cut};
  assign pending_o = pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      pend     <= 1'b0;
      sh_win   <= 2'b00;
      sh_add   <= 1'b0;
      sh_mask  <= '0;
      act_win  <= 2'b00;
      act_add  <= 1'b0;
      act_mask <= '0;
    end else begin
      if (at_end) begin
        cnt <= '0;
        if (pend) begin
          act_win  <= sh_win;
          act_add  <= sh_add;
          act_mask <= sh_mask;
          pend     <= 1'b0;
        end
      end else begin
        cnt <= cnt + 1'b1;
      end
      if (cfg_we) begin
        sh_win  <= cfg_win;
        sh_add  <= cfg_add;
        sh_mask <= cfg_mask;
        pend    <= 1'b1;
      end
    end
  end

  assert_pend_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> pending_o);
  assert_pend_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && at_end && !cfg_we) |=> !pending_o);
  assert_cnt_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= last_cnt);
  assert_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    at_end |=> (cnt == '0));
  assert_tick_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o != 2'd3);
  assert_hold_mid_window_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !at_end |=> ($stable(act_mask) && $stable(act_win) && $stable(act_add)));
endmodule

// File: tb/rtc_trim_bench.sv
module rtc_trim_bench;
  localparam int W = 10;

  logic       clk = 0;
  logic       rst_n = 0;
  logic       cfg_we = 0;
  logic [1:0] cfg_win = 0;
  logic       cfg_add = 0;
  logic [8:0] cfg_mask = 0;
  logic       pending_o;
  logic [1:0] tick_o;

  int tests = 0, fails = 0;
  bit done = 0;

  rtc_trim #(.W(W)) u_rtc_trim (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_win(cfg_win),
    .cfg_add(cfg_add), .cfg_mask(cfg_mask), .pending_o(pending_o), .tick_o(tick_o)
  );

  always #2.5 clk = ~clk;

  function automatic int kof(input logic [1:0] w);
    return w[0] ? 2 : (w[1] ? 1 : 0);
  endfunction

  function automatic int exp_sum(input logic [1:0] w, input bit a, input int m);
    int k = kof(w);
    int me = m & ~((1 << k) - 1);
    return ((1 << W) >> k) + (a ? (512 >> k) : 0) - (me >> k);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  int sum, zeros, badpos, zero_q0;

  task automatic measure(input int len);
    sum = 0; zeros = 0; badpos = 0; zero_q0 = 0;
    for (int i = 0; i < len; i++) begin
      sum += int'(tick_o);
      if (tick_o == 2'd0) begin
        zeros++;
        if (i % 2 != 0) badpos++;
        if (i % 4 == 0) zero_q0++;
      end
      if (tick_o == 2'd2 && i % 2 != 1) badpos++;
      if (tick_o == 2'd3) badpos++;
      @(negedge clk);
    end
  endtask

  task automatic apply(input logic [1:0] w, input bit a, input int m);
    cfg_we = 1; cfg_win = w; cfg_add = a; cfg_mask = 9'(m);
    @(negedge clk);
    cfg_we = 0;
    check("R6 pending after write", int'(pending_o), 1);
    while (pending_o) @(negedge clk);
  endtask

  task automatic run_cfg(input logic [1:0] w, input bit a, input int m);
    int len = (1 << W) >> kof(w);
    apply(w, a, m);
    measure(len);
    case (kof(w))
      0: check("R3 window sum", sum, exp_sum(w, a, m));
      1: check("R4 half window sum", sum, exp_sum(w, a, m));
      default: check("R5 quarter window sum", sum, exp_sum(w, a, m));
    endcase
    check("R8 R7 pulse positions", badpos, 0);
  endtask

  initial begin
    int masks[12] = '{0, 1, 2, 3, 5, 170, 255, 256, 257, 341, 510, 511};
    logic [1:0] wins[3] = '{2'b00, 2'b10, 2'b01};
    #12 rst_n = 1;
    @(negedge clk);
    check("R1 pending after reset", int'(pending_o), 0);
    check("R1 tick after reset", int'(tick_o), 1);
    measure(1 << W);
    check("R1 R3 default window sum", sum, 1 << W);
    check("R1 no removals", zeros, 0);

    foreach (wins[wi])
      for (int a = 0; a < 2; a++)
        foreach (masks[mi])
          run_cfg(wins[wi], a[0], masks[mi]);

    // R2: bit 0 wins over bit 1
    run_cfg(2'b11, 1'b0, 7);
    check("R2 both flags act as quarter", sum, 256 - 1);

    // R8: mask 256 removes in every second slot
    apply(2'b00, 1'b0, 256);
    measure(1 << W);
    check("R8 removals count", zeros, 256);
    check("R8 removals on even slots", zero_q0, 256);

    // R9: write in last cycle of a window
    apply(2'b01, 1'b0, 0);
    measure(256);
    for (int i = 0; i < 255; i++) @(negedge clk);
    cfg_we = 1; cfg_win = 2'b00; cfg_add = 1; cfg_mask = 9'd100;
    @(negedge clk);
    cfg_we = 0;
    check("R9 still pending across boundary", int'(pending_o), 1);
    measure(256);
    check("R9 following window keeps old setting", sum, 256);
    check("R9 applied one window later", int'(pending_o), 0);
    measure(1 << W);
    check("R9 new setting sum", sum, 1024 + 512 - 100);
    done = 1;
  end

  initial begin
    for (int c = 0; c < 190000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule